// File: doc/BRIEF.md
# Timer Output Compare Channel

This block is a single output-compare channel that sits beside a 16-bit timer counter. On every timer clock it compares the counter's current value with an active compare register. When the two are equal, it raises a one-cycle match flag and updates a private output-state bit. The update follows a 2-bit output-mode field, which can toggle, clear or set the bit, or leave it alone. Software can also apply the same action at any moment through a force strobe.

The compare value is written first into a holding register. In normal (non-PWM) operation that value reaches the active compare register on the next clock. In PWM operation it moves across only on a timer clock where the counter reports TOP. The output-mode bits are not held in any such register, so a change to them acts at once.

Writing the counter causes a match-blanking window. This prevents a freshly written count that equals the compare value from producing a match. The pin drive value comes from the output-state bit whenever the mode field is nonzero, and from the general port data bit otherwise. Pin direction always follows the port direction bit.

Top module: `occ_channel`

## Requirements
- R1: After reset the output-state bit is 0, the active compare value is 0 and the match flag is low.
- R2: On a clock where `tick` is high, `cnt_val` equals the active compare value and no blanking applies, `match_pulse` is high for exactly the following cycle. A new matching tick is needed for it to rise again.
- R3: A tick that falls in the same cycle as `cnt_wr`, or the first tick after a `cnt_wr`, produces no match flag and no change to the output-state bit. The tick after that matches normally.
- R4: On a match, mode `01` toggles the output-state bit, `10` clears it, `11` sets it, and `00` leaves it unchanged. In mode `00` the match flag is still raised.
- R5: `pin_out` equals the output-state bit whenever `com_mode` is nonzero and equals `port_data` when `com_mode` is `00`. A change of `com_mode` or `port_data` shows on `pin_out` in the same cycle, without waiting for a clock.
- R6: `pin_oe` always equals `port_dir`, whatever the value of `com_mode`.
- R7: A `force_stb` cycle applies the action selected by `com_mode` to the output-state bit at the next clock edge. It does not raise `match_pulse`.
- R8: With `pwm_mode` low, a `cmp_wr` makes `cmp_din` the active compare value from the next cycle on.
- R9: With `pwm_mode` high, a written compare value waits in the holding register. It becomes active only at a clock where `tick` and `at_top` are both high. Until then, the previous active value keeps producing matches.
- R10: Changing `pwm_mode` does not alter the output-state bit.
- R11: Without `tick`, a counter value equal to the compare value produces no match and no change to the output-state bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer clock enable; one compare evaluation per high cycle |
| cnt_val | input | CNT_W | Current counter value |
| cnt_wr | input | 1 | Counter is being written this cycle |
| at_top | input | 1 | Counter is at TOP this cycle |
| pwm_mode | input | 1 | 1 = PWM operation (compare update at TOP), 0 = normal |
| cmp_wr | input | 1 | Write strobe for the compare holding register |
| cmp_din | input | CNT_W | Compare value being written |
| com_mode | input | 2 | Output mode: 00 off, 01 toggle, 10 clear, 11 set |
| force_stb | input | 1 | Apply the mode action without a match |
| port_data | input | 1 | General port data bit |
| port_dir | input | 1 | General port direction bit (1 = output) |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin output enable |
| match_pulse | output | 1 | One-cycle compare match flag |

## Verification
The bench builds the channel with its default counter width of 16 bits. It therefore exercises the top count 16'hFFFF as a compare value next to small counts. This brings in full-width equality and the change from a small value to the all-ones value in normal mode. The blanking window is tested both with the write on a tick and with the write between ticks. PWM buffering is shown by a stale value that keeps matching until a TOP tick arrives.

// File: rtl/occ_pkg.sv
package occ_pkg;

  typedef enum logic [1:0] {
    COM_OFF = 2'b00,
    COM_TGL = 2'b01,
    COM_CLR = 2'b10,
    COM_SET = 2'b11
  } com_e;

  // Next value of the output-state bit when a match or force is applied.
  function automatic logic oc_next(input com_e mode, input logic cur);
    case (mode)
      COM_TGL: oc_next = ~cur;
      COM_CLR: oc_next = 1'b0;
      COM_SET: oc_next = 1'b1;
      default: oc_next = cur;
    endcase
  endfunction

  // Pin drive select: port logic is overridden whenever any mode bit is set.
  function automatic logic pin_sel(input logic [1:0] mode, input logic oc,
                                   input logic pdata);
    pin_sel = (mode != 2'b00) ? oc : pdata;
  endfunction

endpackage

// File: rtl/occ_cmp_reg.sv
module occ_cmp_reg #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             at_top,
  input  logic             pwm_mode,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_din,
  output logic [CNT_W-1:0] ocr_act
);

  logic [CNT_W-1:0] hold_q;
  logic             top_load;
  logic             now_load;

  assign top_load = pwm_mode & tick & at_top;
  assign now_load = ~pwm_mode & cmp_wr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_q  <= '0;
      ocr_act <= '0;
    end else begin
      if (cmp_wr) hold_q <= cmp_din;
      if (now_load)      ocr_act <= cmp_din;
      else if (top_load) ocr_act <= hold_q;
    end
  end

  // R9
  pwm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode && !(tick && at_top)) |=> $stable(ocr_act));

endmodule

// File: rtl/occ_match_det.sv
module occ_match_det #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_wr,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic [CNT_W-1:0] ocr_act,
  output logic             match_ev,
  output logic             match_pulse
);

  logic blk_q;
  logic blanked;

  assign blanked  = blk_q | cnt_wr;
  assign match_ev = tick & (cnt_val == ocr_act) & ~blanked;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      blk_q       <= 1'b0;
      match_pulse <= 1'b0;
    end else begin
      if (cnt_wr)    blk_q <= 1'b1;
      else if (tick) blk_q <= 1'b0;
      match_pulse <= match_ev;
    end
  end

  // R3
  blank_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && blanked) |=> !match_pulse);

  // R11
  no_tick_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !match_pulse);

  // R2
  match_from_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_pulse |-> $past(tick));

endmodule

// File: rtl/occ_out_state.sv
module occ_out_state
  import occ_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       match_ev,
  input  logic       force_stb,
  input  logic [1:0] com_mode,
  input  logic       port_data,
  input  logic       port_dir,
  output logic       oc_q,
  output logic       pin_out,
  output logic       pin_oe
);

  logic apply;

  assign apply = match_ev | force_stb;

  always_ff @(posedge clk) begin
    if (!rst_n)     oc_q <= 1'b0;
    else if (apply) oc_q <= oc_next(com_e'(com_mode), oc_q);
  end

  assign pin_out = pin_sel(com_mode, oc_q, port_data);
  assign pin_oe  = port_dir;

  // R4
  oc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !apply |=> $stable(oc_q));

  // R4
  oc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && com_mode == 2'b10) |=> !oc_q);

  // R4
  oc_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (apply && com_mode == 2'b11) |=> oc_q);

endmodule

// File: rtl/occ_channel.sv
module occ_channel #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_wr,
  input  logic             at_top,
  input  logic             pwm_mode,
  input  logic             cmp_wr,
  input  logic [CNT_W-1:0] cmp_din,
  input  logic [1:0]       com_mode,
  input  logic             force_stb,
  input  logic             port_data,
  input  logic             port_dir,
  output logic             pin_out,
  output logic             pin_oe,
  output logic             match_pulse
);

  logic [CNT_W-1:0] ocr_act;
  logic             match_ev;
  logic             oc_q;

  occ_cmp_reg #(.CNT_W(CNT_W)) cmp_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .at_top   (at_top),
    .pwm_mode (pwm_mode),
    .cmp_wr   (cmp_wr),
    .cmp_din  (cmp_din),
    .ocr_act  (ocr_act)
  );

  occ_match_det #(.CNT_W(CNT_W)) det_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .cnt_wr      (cnt_wr),
    .cnt_val     (cnt_val),
    .ocr_act     (ocr_act),
    .match_ev    (match_ev),
    .match_pulse (match_pulse)
  );

  occ_out_state out_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .match_ev  (match_ev),
    .force_stb (force_stb),
    .com_mode  (com_mode),
    .port_data (port_data),
    .port_dir  (port_dir),
    .oc_q      (oc_q),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
  );

  // R7
  force_no_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (force_stb && !tick) |=> !match_pulse);

  // R10
  mode_swap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode != $past(pwm_mode) && !match_ev && !force_stb) |=> $stable(oc_q));

endmodule

// File: tb/occ_channel_tb_top.sv
module occ_channel_tb_top;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         tick, cnt_wr, at_top, pwm_mode, cmp_wr, force_stb;
  logic [W-1:0] cnt_val, cmp_din;
  logic [1:0]   com_mode;
  logic         port_data, port_dir;
  logic         pin_out, pin_oe, match_pulse;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  occ_channel #(.CNT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cnt_val(cnt_val), .cnt_wr(cnt_wr),
    .at_top(at_top), .pwm_mode(pwm_mode), .cmp_wr(cmp_wr), .cmp_din(cmp_din),
    .com_mode(com_mode), .force_stb(force_stb), .port_data(port_data),
    .port_dir(port_dir), .pin_out(pin_out), .pin_oe(pin_oe),
    .match_pulse(match_pulse)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic tick_at(input logic [W-1:0] v, input logic top);
    cnt_val = v; at_top = top; tick = 1'b1;
    step();
    tick = 1'b0; at_top = 1'b0;
  endtask

  task automatic load_cmp(input logic [W-1:0] v);
    cmp_din = v; cmp_wr = 1'b1;
    step();
    cmp_wr = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; tick = 0; cnt_wr = 0; at_top = 0; pwm_mode = 0; cmp_wr = 0;
    force_stb = 0; cnt_val = '0; cmp_din = '0; com_mode = 2'b01;
    port_data = 1'b1; port_dir = 1'b0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    chk("R1 match low", match_pulse, 0);
    chk("R1 state zero", pin_out, 0);
    tick_at('0, 0);
    chk("R1 compare zero", match_pulse, 1);
    chk("R1 toggle from zero", pin_out, 1);
  endtask

  task automatic t_normal();
    com_mode = 2'b01; pwm_mode = 0;
    load_cmp(16'd100);
    tick_at(16'd100, 0);
    chk("R2 match", match_pulse, 1);
    chk("R4 toggle", pin_out, 0);
    step();
    chk("R2 one cycle", match_pulse, 0);
    tick_at(16'd99, 0);
    chk("R2 no match", match_pulse, 0);
    chk("R2 state kept", pin_out, 0);
    load_cmp(16'hFFFF);
    tick_at(16'hFFFF, 0);
    chk("R8 new compare", match_pulse, 1);
    chk("R8 toggle", pin_out, 1);
    load_cmp(16'd100);
    tick_at(16'hFFFF, 0);
    chk("R8 old compare gone", match_pulse, 0);
  endtask

  task automatic t_modes();
    com_mode = 2'b10;
    tick_at(16'd100, 0);
    chk("R4 clear", pin_out, 0);
    com_mode = 2'b11;
    tick_at(16'd100, 0);
    chk("R4 set", pin_out, 1);
    com_mode = 2'b10;
    tick_at(16'd100, 0);
    chk("R4 clear again", pin_out, 0);
    com_mode = 2'b00; port_data = 1'b1;
    #1 chk("R5 port data", pin_out, 1);
    tick_at(16'd100, 0);
    chk("R4 off still flags", match_pulse, 1);
    port_data = 1'b0;
    #1 chk("R5 port data follow", pin_out, 0);
    com_mode = 2'b11;
    #1 chk("R4 off left state", pin_out, 0);
    com_mode = 2'b00; port_data = 1'b1;
    #1 chk("R5 unbuffered mode", pin_out, 1);
  endtask

  task automatic t_pin_dir();
    com_mode = 2'b11;
    port_dir = 1'b1;
    #1 chk("R6 dir high", pin_oe, 1);
    port_dir = 1'b0;
    #1 chk("R6 dir low", pin_oe, 0);
    com_mode = 2'b00; port_dir = 1'b1;
    #1 chk("R6 dir off mode", pin_oe, 1);
  endtask

  task automatic t_block();
    com_mode = 2'b01;
    cnt_val = 16'd100; cnt_wr = 1'b1; tick = 1'b1;
    step();
    cnt_wr = 1'b0; tick = 1'b0;
    chk("R3 write tick", match_pulse, 0);
    chk("R3 state write tick", pin_out, 0);
    tick_at(16'd100, 0);
    chk("R3 next tick", match_pulse, 0);
    chk("R3 state next tick", pin_out, 0);
    tick_at(16'd100, 0);
    chk("R3 later match", match_pulse, 1);
    chk("R3 later toggle", pin_out, 1);
    cnt_val = 16'd100; cnt_wr = 1'b1;
    step();
    cnt_wr = 1'b0;
    step();
    tick_at(16'd100, 0);
    chk("R3 gap tick", match_pulse, 0);
    tick_at(16'd100, 0);
    chk("R3 gap later", match_pulse, 1);
    chk("R3 gap toggle", pin_out, 0);
  endtask

  task automatic t_no_tick();
    com_mode = 2'b01; cnt_val = 16'd100; tick = 1'b0;
    step(); step();
    chk("R11 no match", match_pulse, 0);
    chk("R11 state kept", pin_out, 0);
  endtask

  task automatic t_force();
    com_mode = 2'b01; force_stb = 1'b1;
    step();
    force_stb = 1'b0;
    chk("R7 force toggle", pin_out, 1);
    chk("R7 no flag", match_pulse, 0);
    com_mode = 2'b10; force_stb = 1'b1;
    step();
    force_stb = 1'b0;
    chk("R7 force clear", pin_out, 0);
    com_mode = 2'b11; force_stb = 1'b1;
    step();
    force_stb = 1'b0;
    chk("R7 force set", pin_out, 1);
    chk("R7 no flag set", match_pulse, 0);
  endtask

  task automatic t_pwm();
    com_mode = 2'b11; pwm_mode = 1'b1;
    load_cmp(16'd200);
    tick_at(16'd100, 0);
    chk("R9 old value holds", match_pulse, 1);
    tick_at(16'd200, 0);
    chk("R9 buffered not active", match_pulse, 0);
    tick_at(16'd500, 1);
    chk("R9 top tick no match", match_pulse, 0);
    tick_at(16'd200, 0);
    chk("R9 active after top", match_pulse, 1);
    tick_at(16'd100, 0);
    chk("R9 old value gone", match_pulse, 0);
  endtask

  task automatic t_mode_swap();
    com_mode = 2'b01;
    #1 chk("R10 before", pin_out, 1);
    pwm_mode = 1'b0;
    step();
    chk("R10 to normal", pin_out, 1);
    pwm_mode = 1'b1;
    step();
    chk("R10 to pwm", pin_out, 1);
    pwm_mode = 1'b0;
  endtask

  initial begin
    #(8 * 100000);
    n_err++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    t_reset();
    t_normal();
    t_modes();
    t_pin_dir();
    t_block();
    t_no_tick();
    t_force();
    t_pwm();
    t_mode_swap();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule